// File: doc/BRIEF.md
# Interruption Context Save and Restore Unit

This unit holds the processor control state that must survive an interruption. When an interruption is taken, it captures the live status word, the restart point and the current frame marker into a set of saved registers. The restart point is a 16-byte bundle address together with a slot number inside a three-slot bundle. On entry the unit clears the frame marker's valid flag.

While the handler runs, software can overwrite any saved copy. It can also issue a skip command, which moves the restart point past an instruction the handler has emulated. A cover command records the interrupted frame marker and marks it valid.

On return the unit presents the status, restart point and frame marker that control logic loads back into the live registers. The frame marker is loaded only when its valid flag is set. The return outputs are combinational. They show the values the saved registers will hold once this cycle's capture, writes and skip have been applied.

Top module: `icsr_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every saved register (status, bundle address, slot, frame marker) becomes zero and the frame valid flag becomes 0.
- R2: `intr_take` captures `cur_status`, `cur_ip` with bits [3:0] forced to zero and `cur_slot`, and clears the frame valid flag while the frame bits hold. It overrides every write, cover and skip in the same cycle. A captured slot of 3 leaves the saved slot unchanged.
- R3: `cover_req` without `intr_take` or a frame write stores `cur_frame` as the saved frame marker and sets the valid flag. A frame write in the same cycle wins over cover.
- R4: Software writes store the status, the restart point (address bits [3:0] forced to zero; a slot value of 3 leaves the slot unchanged) and the frame marker with its valid flag.
- R5: A single-slot skip (`skip_req`=1, `skip_wide`=0) from slot 0 or 1 increments the slot and leaves the bundle address unchanged.
- R6: A single-slot skip from slot 2 sets the slot to 0 and adds 16 to the bundle address, modulo 2^ADDR_W.
- R7: A two-slot skip (`skip_wide`=1) sets the slot to 0 and adds 16 to the bundle address, whatever the slot was.
- R8: A skip in the same cycle as a restart-point write advances the newly written point. A return in the same cycle presents the advanced point.
- R9: `ret_go` equals `rfi_req` when `intr_take` is low and is 0 otherwise. While it is high, `ret_status`, `ret_ip` and `ret_slot` show the saved values after this cycle's writes and skip.
- R10: `ret_frame_load` is high only with `ret_go` and a set valid flag, counting this cycle's frame write or cover. A return after entry with no cover therefore does not load the frame marker.
- R11: A return by itself changes no saved register.
- R12: The saved slot never holds 3, and the saved bundle address always has bits [3:0] at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| intr_take | input | 1 | Interruption entry strobe |
| cur_status | input | ST_W | Live status word |
| cur_ip | input | ADDR_W | Live instruction address |
| cur_slot | input | 2 | Live slot within bundle |
| cur_frame | input | FM_W | Live frame marker |
| cover_req | input | 1 | Record the live frame marker as valid |
| wr_status_en | input | 1 | Software write of saved status |
| wr_status | input | ST_W | Status write data |
| wr_rp_en | input | 1 | Software write of restart point |
| wr_rp_ip | input | ADDR_W | Restart address write data |
| wr_rp_slot | input | 2 | Restart slot write data |
| wr_frame_en | input | 1 | Software write of saved frame marker |
| wr_frame | input | FM_W | Frame marker write data |
| wr_frame_vld | input | 1 | Valid flag write data |
| skip_req | input | 1 | Advance restart point past one instruction |
| skip_wide | input | 1 | Skipped instruction occupies two slots |
| rfi_req | input | 1 | Return-from-interruption strobe |
| sv_status | output | ST_W | Saved status |
| sv_ip | output | ADDR_W | Saved bundle address |
| sv_slot | output | 2 | Saved slot |
| sv_frame | output | FM_W | Saved frame marker |
| sv_frame_vld | output | 1 | Saved frame valid flag |
| ret_go | output | 1 | Return is being performed |
| ret_status | output | ST_W | Status to restore |
| ret_ip | output | ADDR_W | Bundle address to restore |
| ret_slot | output | 2 | Slot to restore |
| ret_frame_load | output | 1 | Load frame marker on return |
| ret_frame | output | FM_W | Frame marker to restore |

## Verification
The hardest case to reach is a collision: a skip that lands on a slot-2 wrap in the same cycle as a restart-point write and a return, with the bundle address at the top of its range. Directed steps first place the restart point just below the address limit and in each slot. They then apply skips of both widths, alone and together with writes, returns and entries. A long stretch of random cycles follows, in which every strobe is drawn independently, so overlapping commands happen often. A behavioural model checks both the combinational return outputs and the registered state on every cycle.

// File: rtl/icsr_pkg.sv
// Shared constants and helpers for the interruption context unit.
// Assumes a bundle holds three slots and is 16 bytes wide.
package icsr_pkg;
    localparam int SLOTS_PER_BUNDLE = 3;
    localparam int BUNDLE_BYTES     = 16;
    localparam int BUNDLE_LSB       = 4;

    typedef logic [1:0] slot_t;

    // True when the slot number names an existing slot.
    function automatic logic slot_ok(input slot_t s);
        return (int'(s) < SLOTS_PER_BUNDLE);
    endfunction
endpackage

// File: rtl/icsr_status.sv
// Saved status word register.
// Assumes capture and software write may coincide; capture wins.
module icsr_status #(
    parameter int ST_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic [ST_W-1:0] cap_val,
    input  logic            wr_en,
    input  logic [ST_W-1:0] wr_val,
    output logic [ST_W-1:0] st_q,
    output logic [ST_W-1:0] st_nxt
);
    // Next-state selection: capture over write over hold.
    always_comb begin
        st_nxt = st_q;
        if (cap_en)     st_nxt = cap_val;
        else if (wr_en) st_nxt = wr_val;
    end

    // State register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_nxt;
    end

    AST_STATUS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> st_q == $past(cap_val)); // R2
endmodule

// File: rtl/icsr_restart.sv
// Saved restart point: bundle-aligned address plus slot number.
// Applies capture or software write first, then a skip on the result.
// Assumes slot values 0..2 are legal; a 3 offered on capture or write is dropped.
module icsr_restart
    import icsr_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] cap_ip,
    input  slot_t             cap_slot,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_ip,
    input  slot_t             wr_slot,
    input  logic              skip_req,
    input  logic              skip_wide,
    output logic [ADDR_W-1:0] ip_q,
    output slot_t             slot_q,
    output logic [ADDR_W-1:0] ip_nxt,
    output slot_t             slot_nxt
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(BUNDLE_BYTES - 1);
    localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(BUNDLE_BYTES);
    localparam slot_t             LAST_SLOT  = slot_t'(SLOTS_PER_BUNDLE - 1);

    logic [ADDR_W-1:0] base_ip;
    slot_t             base_slot;
    logic              do_skip;

    // Base point: captured or written value, else the held one.
    always_comb begin
        base_ip   = ip_q;
        base_slot = slot_q;
        if (cap_en) begin
            base_ip = cap_ip & ALIGN_MASK;
            if (slot_ok(cap_slot)) base_slot = cap_slot;
        end else if (wr_en) begin
            base_ip = wr_ip & ALIGN_MASK;
            if (slot_ok(wr_slot)) base_slot = wr_slot;
        end
    end

    assign do_skip = skip_req && !cap_en;

    // Skip advance: wide or last-slot skips move to the next bundle.
    always_comb begin
        ip_nxt   = base_ip;
        slot_nxt = base_slot;
        if (do_skip) begin
            if (skip_wide || base_slot == LAST_SLOT) begin
                slot_nxt = '0;
                ip_nxt   = base_ip + STEP;
            end else begin
                slot_nxt = base_slot + slot_t'(1);
            end
        end
    end

    // State register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q   <= '0;
            slot_q <= '0;
        end else begin
            ip_q   <= ip_nxt;
            slot_q <= slot_nxt;
        end
    end

    AST_SLOT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q != 2'd3); // R12
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        ip_q[BUNDLE_LSB-1:0] == '0); // R12
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_req && !skip_wide && !cap_en && !wr_en && slot_q == 2'd2)
        |=> (slot_q == 2'd0 && ip_q == $past(ip_q) + STEP)); // R6
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_req && !skip_wide && !cap_en && !wr_en && slot_q < 2'd2)
        |=> (slot_q == $past(slot_q) + 2'd1 && $stable(ip_q))); // R5
    AST_WIDE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_req && skip_wide && !cap_en && !wr_en)
        |=> (slot_q == 2'd0 && ip_q == $past(ip_q) + STEP)); // R7
endmodule

// File: rtl/icsr_frame.sv
// Saved frame marker with its valid flag.
// Priority: capture clears valid, then software write, then cover.
module icsr_frame #(
    parameter int FM_W = 38
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic            cover_en,
    input  logic [FM_W-1:0] live_frame,
    input  logic            wr_en,
    input  logic [FM_W-1:0] wr_val,
    input  logic            wr_vld,
    output logic [FM_W-1:0] fm_q,
    output logic            vld_q,
    output logic [FM_W-1:0] fm_nxt,
    output logic            vld_nxt
);
    // Next-state selection for marker and valid flag.
    always_comb begin
        fm_nxt  = fm_q;
        vld_nxt = vld_q;
        if (cap_en) begin
            vld_nxt = 1'b0;
        end else if (wr_en) begin
            fm_nxt  = wr_val;
            vld_nxt = wr_vld;
        end else if (cover_en) begin
            fm_nxt  = live_frame;
            vld_nxt = 1'b1;
        end
    end

    // State register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fm_q  <= '0;
            vld_q <= 1'b0;
        end else begin
            fm_q  <= fm_nxt;
            vld_q <= vld_nxt;
        end
    end

    AST_ENTRY_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (!vld_q && $stable(fm_q))); // R2
    AST_COVER_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cover_en && !cap_en && !wr_en)
        |=> (vld_q && fm_q == $past(live_frame))); // R3
endmodule

// File: rtl/icsr_unit.sv
// Top of the interruption context save/restore unit.
// Captures state on entry, accepts handler writes and skip commands,
// and presents restore values on return. Return outputs are combinational
// from the post-update state, so a same-cycle skip is already applied.
module icsr_unit
    import icsr_pkg::*;
#(
    parameter int ST_W   = 32,
    parameter int ADDR_W = 48,
    parameter int FM_W   = 38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              intr_take,
    input  logic [ST_W-1:0]   cur_status,
    input  logic [ADDR_W-1:0] cur_ip,
    input  logic [1:0]        cur_slot,
    input  logic [FM_W-1:0]   cur_frame,
    input  logic              cover_req,
    input  logic              wr_status_en,
    input  logic [ST_W-1:0]   wr_status,
    input  logic              wr_rp_en,
    input  logic [ADDR_W-1:0] wr_rp_ip,
    input  logic [1:0]        wr_rp_slot,
    input  logic              wr_frame_en,
    input  logic [FM_W-1:0]   wr_frame,
    input  logic              wr_frame_vld,
    input  logic              skip_req,
    input  logic              skip_wide,
    input  logic              rfi_req,
    output logic [ST_W-1:0]   sv_status,
    output logic [ADDR_W-1:0] sv_ip,
    output logic [1:0]        sv_slot,
    output logic [FM_W-1:0]   sv_frame,
    output logic              sv_frame_vld,
    output logic              ret_go,
    output logic [ST_W-1:0]   ret_status,
    output logic [ADDR_W-1:0] ret_ip,
    output logic [1:0]        ret_slot,
    output logic              ret_frame_load,
    output logic [FM_W-1:0]   ret_frame
);
    logic [ST_W-1:0]   st_nxt;
    logic [ADDR_W-1:0] ip_nxt;
    slot_t             slot_nxt;
    slot_t             slot_q;
    logic [FM_W-1:0]   fm_nxt;
    logic              vld_nxt;

    icsr_status #(.ST_W(ST_W)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (intr_take),
        .cap_val (cur_status),
        .wr_en   (wr_status_en),
        .wr_val  (wr_status),
        .st_q    (sv_status),
        .st_nxt  (st_nxt)
    );

    icsr_restart #(.ADDR_W(ADDR_W)) u_restart (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (intr_take),
        .cap_ip    (cur_ip),
        .cap_slot  (cur_slot),
        .wr_en     (wr_rp_en),
        .wr_ip     (wr_rp_ip),
        .wr_slot   (wr_rp_slot),
        .skip_req  (skip_req),
        .skip_wide (skip_wide),
        .ip_q      (sv_ip),
        .slot_q    (slot_q),
        .ip_nxt    (ip_nxt),
        .slot_nxt  (slot_nxt)
    );

    icsr_frame #(.FM_W(FM_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (intr_take),
        .cover_en   (cover_req),
        .live_frame (cur_frame),
        .wr_en      (wr_frame_en),
        .wr_val     (wr_frame),
        .wr_vld     (wr_frame_vld),
        .fm_q       (sv_frame),
        .vld_q      (sv_frame_vld),
        .fm_nxt     (fm_nxt),
        .vld_nxt    (vld_nxt)
    );

    assign sv_slot = slot_q;

    // Restore values: entry suppresses a coincident return.
    always_comb begin
        ret_go         = rfi_req && !intr_take;
        ret_status     = st_nxt;
        ret_ip         = ip_nxt;
        ret_slot       = slot_nxt;
        ret_frame      = fm_nxt;
        ret_frame_load = ret_go && vld_nxt;
    end

    AST_RET_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (rfi_req && !intr_take && !wr_status_en && !wr_frame_en && !cover_req)
        |=> ($stable(sv_status) && $stable(sv_frame) && $stable(sv_frame_vld))); // R11
    AST_NO_FRAME_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!sv_frame_vld && !wr_frame_en && !cover_req) |-> !ret_frame_load); // R10
endmodule

// File: tb/test_icsr_unit.sv
module test_icsr_unit;
    localparam int CLK_PERIOD = 10;
    localparam int ST_W   = 32;
    localparam int ADDR_W = 48;
    localparam int FM_W   = 38;
    localparam logic [ADDR_W-1:0] MASK = ~ADDR_W'(15);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic intr_take, cover_req, wr_status_en, wr_rp_en, wr_frame_en, wr_frame_vld;
    logic skip_req, skip_wide, rfi_req;
    logic [ST_W-1:0] cur_status, wr_status;
    logic [ADDR_W-1:0] cur_ip, wr_rp_ip;
    logic [1:0] cur_slot, wr_rp_slot;
    logic [FM_W-1:0] cur_frame, wr_frame;
    logic [ST_W-1:0] sv_status, ret_status;
    logic [ADDR_W-1:0] sv_ip, ret_ip;
    logic [1:0] sv_slot, ret_slot;
    logic [FM_W-1:0] sv_frame, ret_frame;
    logic sv_frame_vld, ret_go, ret_frame_load;

    int n_checks = 0;
    int n_fail = 0;

    // Reference model state.
    logic [ST_W-1:0] m_st;
    logic [ADDR_W-1:0] m_ip;
    int m_slot;
    logic [FM_W-1:0] m_fm;
    logic m_vld;

    always #(CLK_PERIOD/2) clk = ~clk;

    icsr_unit #(.ST_W(ST_W), .ADDR_W(ADDR_W), .FM_W(FM_W)) i_icsr_unit (
        .clk(clk), .rst_n(rst_n), .intr_take(intr_take), .cur_status(cur_status),
        .cur_ip(cur_ip), .cur_slot(cur_slot), .cur_frame(cur_frame),
        .cover_req(cover_req), .wr_status_en(wr_status_en), .wr_status(wr_status),
        .wr_rp_en(wr_rp_en), .wr_rp_ip(wr_rp_ip), .wr_rp_slot(wr_rp_slot),
        .wr_frame_en(wr_frame_en), .wr_frame(wr_frame), .wr_frame_vld(wr_frame_vld),
        .skip_req(skip_req), .skip_wide(skip_wide), .rfi_req(rfi_req),
        .sv_status(sv_status), .sv_ip(sv_ip), .sv_slot(sv_slot), .sv_frame(sv_frame),
        .sv_frame_vld(sv_frame_vld), .ret_go(ret_go), .ret_status(ret_status),
        .ret_ip(ret_ip), .ret_slot(ret_slot), .ret_frame_load(ret_frame_load),
        .ret_frame(ret_frame)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        intr_take = 0; cover_req = 0; wr_status_en = 0; wr_rp_en = 0;
        wr_frame_en = 0; wr_frame_vld = 0; skip_req = 0; skip_wide = 0; rfi_req = 0;
    endtask

    task automatic check_saved(input string tag);
        check(tag, "sv_status", 64'(sv_status), 64'(m_st));
        check(tag, "sv_ip", 64'(sv_ip), 64'(m_ip));
        check(tag, "sv_slot", 64'(sv_slot), 64'(m_slot));
        check(tag, "sv_frame", 64'(sv_frame), 64'(m_fm));
        check(tag, "sv_frame_vld", 64'(sv_frame_vld), 64'(m_vld));
    endtask

    // One clock: model the cycle, check return outputs, clock, check state.
    task automatic step(input string tag);
        logic [ST_W-1:0] n_st;
        logic [ADDR_W-1:0] n_ip;
        int n_slot;
        logic [FM_W-1:0] n_fm;
        logic n_vld, e_go;
        #1;
        n_st = m_st; n_ip = m_ip; n_slot = m_slot; n_fm = m_fm; n_vld = m_vld;
        if (intr_take) begin
            n_st = cur_status;
            n_ip = cur_ip & MASK;
            if (cur_slot != 2'd3) n_slot = int'(cur_slot);
            n_vld = 0;
        end else begin
            if (wr_status_en) n_st = wr_status;
            if (wr_rp_en) begin
                n_ip = wr_rp_ip & MASK;
                if (wr_rp_slot != 2'd3) n_slot = int'(wr_rp_slot);
            end
            if (skip_req) begin
                if (skip_wide) begin
                    n_slot = 0; n_ip = n_ip + ADDR_W'(16);
                end else begin
                    n_slot = n_slot + 1;
                    if (n_slot == 3) begin n_slot = 0; n_ip = n_ip + ADDR_W'(16); end
                end
            end
            if (wr_frame_en) begin n_fm = wr_frame; n_vld = wr_frame_vld; end
            else if (cover_req) begin n_fm = cur_frame; n_vld = 1; end
        end
        e_go = rfi_req && !intr_take;
        check(tag, "ret_go", 64'(ret_go), 64'(e_go));
        check(tag, "ret_frame_load", 64'(ret_frame_load), 64'(e_go && n_vld));
        if (e_go) begin
            check(tag, "ret_status", 64'(ret_status), 64'(n_st));
            check(tag, "ret_ip", 64'(ret_ip), 64'(n_ip));
            check(tag, "ret_slot", 64'(ret_slot), 64'(n_slot));
            if (n_vld) check(tag, "ret_frame", 64'(ret_frame), 64'(n_fm));
        end
        @(posedge clk);
        m_st = n_st; m_ip = n_ip; m_slot = n_slot; m_fm = n_fm; m_vld = n_vld;
        @(negedge clk);
        idle();
        check_saved(tag);
    endtask

    task automatic set_rp(input logic [ADDR_W-1:0] a, input logic [1:0] s, input string tag);
        wr_rp_en = 1; wr_rp_ip = a; wr_rp_slot = s; step(tag);
    endtask

    initial begin
        idle();
        cur_status = '0; cur_ip = '0; cur_slot = '0; cur_frame = '0;
        wr_status = '0; wr_rp_ip = '0; wr_rp_slot = '0; wr_frame = '0;
        m_st = '0; m_ip = '0; m_slot = 0; m_fm = '0; m_vld = 0;
        // Load non-zero state, then reset.
        rst_n = 1;
        @(negedge clk);
        wr_status_en = 1; wr_status = 32'hDEAD_BEEF;
        wr_frame_en = 1; wr_frame = 38'h15_5555_5555; wr_frame_vld = 1;
        wr_rp_en = 1; wr_rp_ip = 48'h1234_5678_9AB0; wr_rp_slot = 2'd1;
        @(negedge clk);
        idle();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        check_saved("R1");
        rst_n = 1;

        // R2: entry with unaligned address
        intr_take = 1; cur_status = 32'h0000_A5A5; cur_ip = 48'h0000_1234_5677;
        cur_slot = 2'd1; cur_frame = 38'h00_0000_0ABC; step("R2");
        // R3: cover records frame
        cover_req = 1; cur_frame = 38'h3F_0000_1234; step("R3");
        // R2: entry beats cover, write, skip and return
        intr_take = 1; cover_req = 1; skip_req = 1; rfi_req = 1;
        wr_status_en = 1; wr_status = 32'h1111_2222; cur_status = 32'h3333_4444;
        cur_ip = 48'h0000_0000_0100; cur_slot = 2'd2; step("R2");
        // R2: captured slot 3 keeps the saved slot
        intr_take = 1; cur_slot = 2'd3; cur_ip = 48'h0000_0000_0208; step("R2");
        // R10: return after entry with no cover does not load frame
        rfi_req = 1; step("R10");
        // R4: software writes
        wr_status_en = 1; wr_status = 32'hCAFE_0001;
        wr_frame_en = 1; wr_frame = 38'h2A_AAAA_0001; wr_frame_vld = 1;
        step("R4");
        set_rp(48'h0000_0000_400F, 2'd0, "R4");
        set_rp(48'h0000_0000_5000, 2'd3, "R4");
        // R3: frame write wins over cover
        cover_req = 1; cur_frame = 38'h01_0101_0101;
        wr_frame_en = 1; wr_frame = 38'h02_0202_0202; wr_frame_vld = 0; step("R3");
        // R5 and R6: single skips through a bundle
        skip_req = 1; step("R5");
        skip_req = 1; step("R5");
        skip_req = 1; step("R6");
        // R6: wrap of the address at the top
        set_rp({ADDR_W{1'b1}}, 2'd2, "R4");
        skip_req = 1; step("R6");
        // R7: wide skips from slot 0 and slot 1
        set_rp(48'h0000_0000_7000, 2'd0, "R4");
        skip_wide = 1; skip_req = 1; step("R7");
        set_rp(48'h0000_0000_7000, 2'd1, "R4");
        skip_wide = 1; skip_req = 1; step("R7");
        // R8: skip on the written point, with return
        wr_rp_en = 1; wr_rp_ip = 48'h0000_0000_9000; wr_rp_slot = 2'd2;
        skip_req = 1; rfi_req = 1; step("R8");
        // R9 and R10: return with cover in the same cycle
        rfi_req = 1; cover_req = 1; cur_frame = 38'h0F_F0F0_F0F0; step("R10");
        // R11: return alone changes nothing
        rfi_req = 1; step("R11");
        rfi_req = 1; step("R9");

        // Random mixed traffic.
        for (int i = 0; i < 400; i++) begin
            intr_take = ($urandom_range(0, 9) == 0);
            cover_req = ($urandom_range(0, 4) == 0);
            wr_status_en = ($urandom_range(0, 3) == 0);
            wr_rp_en = ($urandom_range(0, 3) == 0);
            wr_frame_en = ($urandom_range(0, 5) == 0);
            wr_frame_vld = 1'($urandom);
            skip_req = ($urandom_range(0, 2) == 0);
            skip_wide = ($urandom_range(0, 3) == 0);
            rfi_req = ($urandom_range(0, 2) == 0);
            cur_status = $urandom; wr_status = $urandom;
            cur_ip = ADDR_W'({$urandom, $urandom});
            wr_rp_ip = (i % 7 == 0) ? {ADDR_W{1'b1}} : ADDR_W'({$urandom, $urandom});
            cur_slot = 2'($urandom); wr_rp_slot = 2'($urandom);
            cur_frame = FM_W'({$urandom, $urandom}); wr_frame = FM_W'({$urandom, $urandom});
            step("R9");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule